// File: doc/BRIEF.md
# Bus-Clocked Wiper Step Controller

This block nudges one channel's wiper code by a single position for every serial clock pulse on a two-wire bus, after the command executor has accepted an increment/decrement instruction. The executor raises a one-cycle arm strobe together with the channel index. From then on the block watches the synchronized clock and data lines. Each rising edge of the clock line is treated as one step. The level of the data line at that edge sets the direction. There is no byte framing and no acknowledge bit.

Every step that changes the code comes out as a one-cycle write strobe carrying the channel and the new code. The wiper register file that receives it lives outside this block and feeds its current codes back in. The mode ends when a STOP or a START condition is seen on the lines. The change is volatile only: no stored copy is touched.

Top module: `wiper_stepper`

## Requirements
- R1: After reset `modeActive` and `wrEn` are 0. A cycle with `armIn`=1 sets `modeActive` to 1 on the next cycle and latches `armChan` as the selected channel.
- R2: While the mode is active, a rising edge of `sclIn` with `sdaIn`=1 at that edge makes `wrEn` high for exactly one cycle, starting in the cycle after the edge is sampled. It carries `wrChan` = the selected channel and `wrData` = that channel's current code + 1.
- R3: While the mode is active, a rising edge of `sclIn` with `sdaIn`=0 produces the same one-cycle write with `wrData` = current code − 1.
- R4: Up and down pulses may be mixed in any order. Each step starts from the code that the channel currently presents on `wiperIn`, in bits [ch*8 +: 8].
- R5: An up step on a channel whose code is 255 produces no write, so the code stays at 255 and never wraps.
- R6: A down step on a channel whose code is 0 produces no write, so the code stays at 0 and never wraps.
- R7: A STOP (`sdaIn` rising while `sclIn` stays high) clears `modeActive` on the next cycle without a write. Later clock pulses change nothing until the block is armed again. The clock rise that comes before the STOP is an ordinary step.
- R8: A START (`sdaIn` falling while `sclIn` stays high) ends the mode in the same way as R7.
- R9: While `modeActive` is 0, clock pulses never produce a write.
- R10: Arming again while the mode is active switches the selected channel to the new `armChan`. Other channels are left alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| armIn | input | 1 | One-cycle strobe from the command executor: enter step mode |
| armChan | input | 2 | Channel index captured with `armIn` |
| sclIn | input | 1 | Synchronized bus clock line |
| sdaIn | input | 1 | Synchronized bus data line |
| wiperIn | input | 32 | Current codes of all channels, channel ch in bits [ch*8 +: 8] |
| modeActive | output | 1 | Step mode is active |
| wrEn | output | 1 | One-cycle write strobe to the wiper register file |
| wrChan | output | 2 | Channel written |
| wrData | output | 8 | New wiper code |

## Verification
The hardest situations to reach are a clock rise that lands on a saturated code, and an exit condition that comes right after a step. The second needs the clock held high while the data line toggles, which an ordinary step sequence never does. The bench preloads the external register file near its limits (253 and 2), so a few pulses drive each channel into saturation. It then ends sequences with a step rise followed at once by a data transition while the clock stays high. A behavioural model, run in lockstep, predicts every strobe. This shows that the final rise is applied, the exit adds no step, and later pulses are ignored.

// File: rtl/wstep_pkg.sv
package wstep_pkg;
  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic step;   // apply one step this cycle
    logic up;     // direction of the step
    logic leave;  // exit condition seen
  } stepCmd_t;
endpackage

// File: rtl/wstep_ctrl.sv
module wstep_ctrl
  import wstep_pkg::*;
#(
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            armIn,
  input  logic [CH_W-1:0] armChan,
  input  logic            sclIn,
  input  logic            sdaIn,
  output stepCmd_t        cmd,
  output logic            active,
  output logic [CH_W-1:0] chanQ
);
  logic sclPrev, sdaPrev;
  logic sclRise, startSeen, stopSeen;

  // Idle bus level is high on both lines.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclIn;
      sdaPrev <= sdaIn;
    end
  end

  always_comb begin
    sclRise   = sclIn & ~sclPrev;
    startSeen = sclPrev & sclIn & sdaPrev & ~sdaIn;
    stopSeen  = sclPrev & sclIn & ~sdaPrev & sdaIn;
    cmd.step  = active & sclRise;
    cmd.up    = sdaIn;
    cmd.leave = active & (startSeen | stopSeen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      chanQ  <= '0;
    end else if (armIn) begin
      active <= 1'b1;
      chanQ  <= armChan;
    end else if (cmd.leave) begin
      active <= 1'b0;
    end
  end

  // R1
  arm_enters_chk: assert property (@(posedge clk) disable iff (!rstN)
    armIn |=> (active && chanQ == $past(armChan)));

  // R7
  leave_exits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && (startSeen || stopSeen) && !armIn) |=> !active);

  // R10
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && !armIn) |=> $stable(chanQ));
endmodule

// File: rtl/wstep_data.sv
module wstep_data
  import wstep_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  stepCmd_t                 cmd,
  input  logic [CH_W-1:0]          chanQ,
  input  logic [NUM_CH*CODE_W-1:0] wiperIn,
  output logic                     wrEn,
  output logic [CH_W-1:0]          wrChan,
  output logic [CODE_W-1:0]        wrData
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

  logic [CODE_W-1:0] codes [NUM_CH];
  logic [CODE_W-1:0] curCode, nextCode;
  logic              atLimit;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
    assign codes[g] = wiperIn[g*CODE_W +: CODE_W];
  end

  always_comb begin
    curCode  = codes[chanQ];
    atLimit  = cmd.up ? (curCode == CODE_MAX) : (curCode == '0);
    nextCode = cmd.up ? curCode + CODE_ONE : curCode - CODE_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrEn   <= 1'b0;
      wrChan <= '0;
      wrData <= '0;
    end else begin
      wrEn   <= cmd.step & ~atLimit;
      wrChan <= chanQ;
      wrData <= nextCode;
    end
  end

  // R2 R3
  step_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (wrData == $past(curCode) + CODE_ONE || wrData == $past(curCode) - CODE_ONE));

  // R5 R6
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !((wrData == '0 && $past(curCode) == CODE_MAX) ||
               (wrData == CODE_MAX && $past(curCode) == '0)));

  // R2
  single_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);
endmodule

// File: rtl/wiper_stepper.sv
module wiper_stepper
  import wstep_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     armIn,
  input  logic [CH_W-1:0]          armChan,
  input  logic                     sclIn,
  input  logic                     sdaIn,
  input  logic [NUM_CH*CODE_W-1:0] wiperIn,
  output logic                     modeActive,
  output logic                     wrEn,
  output logic [CH_W-1:0]          wrChan,
  output logic [CODE_W-1:0]        wrData
);
  stepCmd_t        cmd;
  logic [CH_W-1:0] chanQ;

  wstep_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .armIn(armIn), .armChan(armChan),
    .sclIn(sclIn), .sdaIn(sdaIn), .cmd(cmd), .active(modeActive), .chanQ(chanQ)
  );

  wstep_data #(.CODE_W(CODE_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_data (
    .clk(clk), .rstN(rstN), .cmd(cmd), .chanQ(chanQ), .wiperIn(wiperIn),
    .wrEn(wrEn), .wrChan(wrChan), .wrData(wrData)
  );

  // R9
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeActive |=> !wrEn);
endmodule

// File: tb/sim_wiper_stepper.sv
module sim_wiper_stepper;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic armIn = 1'b0;
  logic [1:0] armChan = '0;
  logic sclIn = 1'b1;
  logic sdaIn = 1'b1;
  logic [31:0] wiperIn;
  logic modeActive, wrEn;
  logic [1:0] wrChan;
  logic [7:0] wrData;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit done = 0;

  // bench-owned wiper register file
  int regs [4];
  // reference model state
  int mPrevScl = 1, mPrevSda = 1, mAct = 0, mChan = 0;
  int eWr = 0, eChan = 0, eData = 0;

  always #2.5 clk = ~clk;

  always_comb
    for (int i = 0; i < 4; i++) wiperIn[i*8 +: 8] = 8'(regs[i]);

  wiper_stepper u0 (
    .clk(clk), .rstN(rstN), .armIn(armIn), .armChan(armChan),
    .sclIn(sclIn), .sdaIn(sdaIn), .wiperIn(wiperIn),
    .modeActive(modeActive), .wrEn(wrEn), .wrChan(wrChan), .wrData(wrData)
  );

  // reference model, one update per clock
  always @(posedge clk) begin
    int rise, st, sp, nWr, nData, c;
    if (!rstN) begin
      mPrevScl = 1; mPrevSda = 1; mAct = 0; mChan = 0; eWr = 0;
    end else begin
      rise = sclIn && !mPrevScl;
      st = mPrevScl && sclIn && mPrevSda && !sdaIn;
      sp = mPrevScl && sclIn && !mPrevSda && sdaIn;
      nWr = 0; nData = 0;
      if (mAct && rise) begin
        c = regs[mChan];
        if (sdaIn && c < 255) begin nWr = 1; nData = c + 1; end
        else if (!sdaIn && c > 0) begin nWr = 1; nData = c - 1; end
      end
      if (eWr != 0) regs[eChan] = eData;
      eWr = nWr; eData = nData; eChan = mChan;
      if (armIn) begin mAct = 1; mChan = int'(armChan); end
      else if (mAct && (st || sp)) mAct = 0;
      mPrevScl = sclIn; mPrevSda = sdaIn;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (int'(modeActive) != mAct || int'(wrEn) != eWr ||
          (eWr != 0 && (int'(wrChan) != eChan || int'(wrData) != eData))) begin
        errors++;
        $display("FAIL %s cycle act=%0d/%0d/%0d/%0d exp=%0d/%0d/%0d/%0d", curReq,
                 modeActive, wrEn, wrChan, wrData, mAct, eWr, eChan, eData);
      end
    end
  end

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input bit d);
    sclIn = 1'b0; sdaIn = d; waitN(2);
    sclIn = 1'b1; waitN(3);
    sclIn = 1'b0; waitN(2);
  endtask

  // down-step rise, then STOP
  task automatic stopExit();
    sclIn = 1'b0; sdaIn = 1'b0; waitN(2);
    sclIn = 1'b1; waitN(2);
    sdaIn = 1'b1; waitN(3);
  endtask

  // up-step rise, then START
  task automatic startExit();
    sclIn = 1'b0; sdaIn = 1'b1; waitN(2);
    sclIn = 1'b1; waitN(2);
    sdaIn = 1'b0; waitN(2);
    sclIn = 1'b0; waitN(2);
  endtask

  task automatic arm(input int ch);
    armIn = 1'b1; armChan = 2'(ch); waitN(1);
    armIn = 1'b0; waitN(1);
  endtask

  task automatic expectReg(input string req, input int ch, input int exp);
    checks++;
    if (regs[ch] != exp) begin
      errors++;
      $display("FAIL %s reg%0d act=%0d exp=%0d", req, ch, regs[ch], exp);
    end
  endtask

  task automatic expectAct(input string req, input int exp);
    checks++;
    if (int'(modeActive) != exp) begin
      errors++;
      $display("FAIL %s modeActive act=%0d exp=%0d", req, modeActive, exp);
    end
  endtask

  initial begin
    regs[0] = 10; regs[1] = 20; regs[2] = 30; regs[3] = 40;
    waitN(3);
    rstN = 1'b1; waitN(1);
    // R1: reset state
    expectAct("R1", 0);
    checks++;
    if (wrEn !== 1'b0) begin errors++; $display("FAIL R1 wrEn act=%0d exp=0", wrEn); end

    // R9: pulses before arming do nothing
    curReq = "R9";
    pulse(1); pulse(1); pulse(0);
    expectReg("R9", 0, 10); expectReg("R9", 1, 20);

    // R2, R3, R4 on channel 1
    curReq = "R1";
    arm(1);
    expectAct("R1", 1);
    curReq = "R2";
    pulse(1); pulse(1); pulse(1);
    expectReg("R2", 1, 23);
    curReq = "R3";
    for (int i = 0; i < 5; i++) pulse(0);
    expectReg("R3", 1, 18);
    curReq = "R4";
    pulse(1); pulse(0); pulse(1);
    expectReg("R4", 1, 19);

    // R8: START exit after an up rise
    curReq = "R8";
    startExit();
    expectReg("R8", 1, 20);
    expectAct("R8", 0);
    pulse(1); pulse(1);
    expectReg("R8", 1, 20);

    // R5: saturation at the top
    curReq = "R5";
    regs[2] = 253;
    arm(2);
    for (int i = 0; i < 4; i++) pulse(1);
    expectReg("R5", 2, 255);
    startExit();
    expectReg("R5", 2, 255);

    // R6: saturation at the bottom, R7 STOP exit
    curReq = "R6";
    regs[3] = 2;
    arm(3);
    for (int i = 0; i < 4; i++) pulse(0);
    expectReg("R6", 3, 0);
    curReq = "R7";
    stopExit();
    expectReg("R7", 3, 0);
    expectAct("R7", 0);
    pulse(1); pulse(1);
    expectReg("R7", 3, 0);

    // R7: STOP exit with a live down step before it
    arm(0);
    pulse(1);
    expectReg("R7", 0, 11);
    stopExit();
    expectReg("R7", 0, 10);
    pulse(1);
    expectReg("R7", 0, 10);

    // R10: re-arm while active switches channel
    curReq = "R10";
    arm(0);
    arm(3);
    pulse(1); pulse(1);
    expectReg("R10", 3, 2);
    expectReg("R10", 0, 10);
    startExit();
    expectReg("R10", 3, 3);

    waitN(4);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule